// File: doc/BRIEF.md
# External interrupt request front end with vector selection

This block sits between a small 8-bit processor core and its interrupt sources. An active-low external request pin is brought into the clock domain by two flip-flops. It is then qualified by a minimum low time, and the result sets a pending latch. Three internal sources (timer, SPI, port B) arrive as level request lines whose flags are kept by their own peripherals. A configuration input chooses whether only a falling edge raises the external request, or whether a sustained low level raises it as well. The level setting suits a wired-OR request line.

The core pulses `insn_end` on the last cycle of every instruction. The block decides to take an interrupt only at that moment, and only when its mask is clear. When it takes one, it pulses `take` for one cycle, sets the mask, and registers the address pair of the winning vector. The core acknowledges early in its service sequence with `svc_clr`, which empties the external pending latch. A qualified edge that arrives after that is held until software clears the mask again through `mask_wr`.

Top module: `irq_front`

## Requirements
- R1: During reset and directly after it, `take` is 0, `irq_pend` is 0, `mask` is 1, `vec_hi` is 16'h0000 and `vec_lo` is 16'h0001.
- R2: `irq_n` passes through two synchronising flops. `irq_pend` goes to 1 once `MIN_LOW` consecutive synchronised samples have been low (default 2). A low shorter than that leaves `irq_pend` at 0. With the pin low before clock edge k, `irq_pend` reads 1 after edge k+1+`MIN_LOW`.
- R3: With `level_mode` = 0 (edge only), a pin that stays low after `svc_clr` has cleared the latch does not set it again. The pin must go high and then low again.
- R4: With `level_mode` = 1, a pin held low sets the latch on every cycle. If the pin is still low after a clear or after a service, the request is raised again.
- R5: `take` is a one-cycle pulse. It rises on the clock edge that samples `insn_end` = 1 with `mask` = 0 and at least one request (external latch, `timer_req`, `spi_req` or `pb_req`). It never rises on two consecutive cycles.
- R6: Reset sets `mask`, and a taken interrupt sets it. In other cycles, `mask_wr` = 1 loads `mask_val`. If a take and `mask_wr` fall on the same edge, the take wins. While `mask` is 1, no take occurs and the pending latch keeps its value.
- R7: The priority order is: external first, then timer, then SPI, then port B. On a take, `vec_hi`/`vec_lo` load 16'h1FFA/16'h1FFB for external, 16'h1FF8/16'h1FF9 for timer, 16'h1FF4/16'h1FF5 for SPI and 16'h1FF2/16'h1FF3 for port B. The pair holds until the next take.
- R8: `svc_clr` = 1 clears the external latch. A qualified edge or level on the same edge takes precedence, so exactly one further request can be captured during service.
- R9: `timer_req`, `spi_req` and `pb_req` are not latched by the block. A take occurs for them only if they are high at the instruction boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | External request pin, active low, asynchronous |
| level_mode | input | 1 | 0: falling edge only; 1: edge plus low level |
| timer_req | input | 1 | Timer request level |
| spi_req | input | 1 | SPI request level |
| pb_req | input | 1 | Port B request level |
| insn_end | input | 1 | Last cycle of the current instruction |
| svc_clr | input | 1 | Clear of the external latch from the service sequence |
| mask_wr | input | 1 | Write strobe for the mask |
| mask_val | input | 1 | Value written to the mask |
| take | output | 1 | One-cycle pulse: begin interrupt service |
| vec_hi | output | 16 | Address of the vector high byte |
| vec_lo | output | 16 | Address of the vector low byte |
| irq_pend | output | 1 | External pending latch |
| mask | output | 1 | Interrupt mask |

## Verification
Two collisions matter. The first is a clear of the pending latch in the same cycle that a new qualified edge would set it. The second is a mask write on the same boundary as a take. The bench acknowledges each take one cycle later and sweeps the pin's falling edge across a range of offsets around that acknowledgement. It also holds a mask write active while a timer request keeps producing takes. Every cycle's `irq_pend`, `mask`, `take` and vector pair are then judged against a behavioural model, in which a set beats a clear and a take beats a mask write.

// File: rtl/irq_front.sv
module irq_front #(
  parameter int          MIN_LOW = 2,
  parameter logic [15:0] VEC_IRQ = 16'h1FFA,
  parameter logic [15:0] VEC_TMR = 16'h1FF8,
  parameter logic [15:0] VEC_SPI = 16'h1FF4,
  parameter logic [15:0] VEC_PB  = 16'h1FF2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        level_mode,
  input  logic        timer_req,
  input  logic        spi_req,
  input  logic        pb_req,
  input  logic        insn_end,
  input  logic        svc_clr,
  input  logic        mask_wr,
  input  logic        mask_val,
  output logic        take,
  output logic [15:0] vec_hi,
  output logic [15:0] vec_lo,
  output logic        irq_pend,
  output logic        mask
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW);
  localparam logic [CW-1:0] CNT_HIT  = CW'(MIN_LOW - 1);

  logic          s1, s2;
  logic [CW-1:0] lowcnt;
  logic          hit_edge, hit_lvl, pend_set, any_req, go;
  logic [15:0]   win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= irq_n;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              lowcnt <= '0;
    else if (s2)             lowcnt <= '0;
    else if (lowcnt != CNT_MAX) lowcnt <= lowcnt + 1'b1;
  end

  assign hit_edge = !s2 && (lowcnt == CNT_HIT);
  assign hit_lvl  = !s2 && (lowcnt >= CNT_HIT);
  assign pend_set = hit_edge || (level_mode && hit_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_pend <= 1'b0;
    else if (pend_set) irq_pend <= 1'b1;
    else if (svc_clr)  irq_pend <= 1'b0;
  end

  assign any_req = irq_pend | timer_req | spi_req | pb_req;
  assign go      = insn_end && !mask && any_req;

  always_comb begin
    if (irq_pend)       win = VEC_IRQ;
    else if (timer_req) win = VEC_TMR;
    else if (spi_req)   win = VEC_SPI;
    else                win = VEC_PB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take   <= 1'b0;
      mask   <= 1'b1;
      vec_hi <= 16'h0000;
      vec_lo <= 16'h0001;
    end else begin
      take <= go;
      if (go) begin
        mask   <= 1'b1;
        vec_hi <= win;
        vec_lo <= win + 16'd1;
      end else if (mask_wr) begin
        mask <= mask_val;
      end
    end
  end
endmodule

module irq_front_chk #(
  parameter logic [15:0] VEC_IRQ = 16'h1FFA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_end,
  input logic        svc_clr,
  input logic        take,
  input logic [15:0] vec_hi,
  input logic [15:0] vec_lo,
  input logic        irq_pend,
  input logic        mask
);
  p_take_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_take_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_end));
  p_masked_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !take);
  p_take_sets_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> mask);
  p_irq_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(irq_pend)) |-> (vec_hi == VEC_IRQ));
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> ($stable(vec_hi) && $stable(vec_lo)));
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !svc_clr) |=> irq_pend);
endmodule

bind irq_front irq_front_chk #(.VEC_IRQ(VEC_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .svc_clr(svc_clr),
  .take(take), .vec_hi(vec_hi), .vec_lo(vec_lo), .irq_pend(irq_pend),
  .mask(mask)
);

// File: tb/irq_front_tb.sv
`timescale 1ns/1ps
module irq_front_tb;
  localparam int MIN_LOW = 2;

  logic clk = 0, rst_n = 0;
  logic irq_n = 1, level_mode = 0, timer_req = 0, spi_req = 0, pb_req = 0;
  logic insn_end = 0, svc_clr = 0, mask_wr = 0, mask_val = 1;
  logic take, irq_pend, mask;
  logic [15:0] vec_hi, vec_lo;

  logic man_clr = 0, auto_clr = 1;
  int   ie_cnt = 0, ntake = 0, cycles = 0;
  int   n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_front #(.MIN_LOW(MIN_LOW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .level_mode(level_mode),
    .timer_req(timer_req), .spi_req(spi_req), .pb_req(pb_req),
    .insn_end(insn_end), .svc_clr(svc_clr), .mask_wr(mask_wr),
    .mask_val(mask_val), .take(take), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .irq_pend(irq_pend), .mask(mask)
  );

  // instruction boundaries every third cycle; acknowledge each take a cycle later
  always @(negedge clk) begin
    ie_cnt   = (ie_cnt + 1) % 3;
    insn_end <= (ie_cnt == 2);
    svc_clr  <= (auto_clr && take) || man_clr;
  end

  // behavioural reference
  bit m_s1 = 1, m_s2 = 1, m_pend = 0, m_mask = 1, m_take = 0;
  int m_len = 0;
  logic [15:0] m_vhi = 16'h0000;

  always @(posedge clk) begin
    int  len_now;
    bit  setv, go;
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_len <= 0; m_pend <= 0;
      m_mask <= 1; m_take <= 0; m_vhi <= 16'h0000;
    end else begin
      len_now = m_s2 ? 0 : ((m_len > 1000) ? m_len : m_len + 1);
      setv = (len_now == MIN_LOW) || (level_mode && len_now >= MIN_LOW);
      go = insn_end && !m_mask && (m_pend || timer_req || spi_req || pb_req);
      m_s1 <= irq_n; m_s2 <= m_s1; m_len <= len_now;
      m_pend <= setv ? 1'b1 : (svc_clr ? 1'b0 : m_pend);
      m_take <= go;
      if (go) begin
        m_mask <= 1;
        m_vhi  <= m_pend ? 16'h1FFA : timer_req ? 16'h1FF8 :
                  spi_req ? 16'h1FF4 : 16'h1FF2;
      end else if (mask_wr) m_mask <= mask_val;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (take) ntake++;
    if (rst_n) begin
      chk("R5 take", {31'd0, take}, {31'd0, m_take});
      chk("R7 vec_hi", {16'd0, vec_hi}, {16'd0, m_vhi});
      chk("R7 vec_lo", {16'd0, vec_lo}, {16'd0, m_vhi + 16'd1});
      chk("R2/R8 pend", {31'd0, irq_pend}, {31'd0, m_pend});
      chk("R6 mask", {31'd0, mask}, {31'd0, m_mask});
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unmask();
    @(negedge clk); mask_wr = 1; mask_val = 0;
    @(negedge clk); mask_wr = 0; mask_val = 1;
  endtask

  task automatic clr_pulse();
    @(negedge clk); man_clr = 1;
    @(negedge clk); man_clr = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int t0;
    step(3);
    chk("R1 take", {31'd0, take}, 32'd0);
    chk("R1 pend", {31'd0, irq_pend}, 32'd0);
    chk("R1 mask", {31'd0, mask}, 32'd1);
    chk("R1 vec", {vec_hi, vec_lo}, 32'h0000_0001);
    rst_n = 1;
    step(4);

    // latch behaviour while masked
    irq_n = 0; step(1); irq_n = 1; step(8);
    chk("R2 short low", {31'd0, irq_pend}, 32'd0);
    irq_n = 0; step(6);
    chk("R2 long low", {31'd0, irq_pend}, 32'd1);
    chk("R6 no take masked", ntake, 0);
    clr_pulse(); step(6);
    chk("R3 held low no reset", {31'd0, irq_pend}, 32'd0);
    irq_n = 1; step(3); irq_n = 0; step(6);
    chk("R3 new edge", {31'd0, irq_pend}, 32'd1);
    level_mode = 1; clr_pulse(); step(4);
    chk("R4 level re-set", {31'd0, irq_pend}, 32'd1);
    irq_n = 1; step(3); clr_pulse(); step(4);
    chk("R4 level released", {31'd0, irq_pend}, 32'd0);

    // level request held across a service
    irq_n = 0; step(4); t0 = ntake;
    unmask(); step(10); unmask(); step(10);
    chk("R4 served twice", ntake - t0, 2);
    irq_n = 1; level_mode = 0; step(4);
    clr_pulse(); step(2);

    // sweep pin edge against the acknowledgement
    for (int d = 0; d < 9; d++) begin
      irq_n = 0; step(3); irq_n = 1;
      unmask(); step(d);
      irq_n = 0; step(3); irq_n = 1; step(12);
    end
    unmask(); step(12);

    // priority and unlatched internal requests
    irq_n = 0; step(3); irq_n = 1; step(4);
    timer_req = 1; spi_req = 1; pb_req = 1;
    unmask(); step(8);
    chk("R7 irq wins", {16'd0, vec_hi}, 32'h1FFA);
    unmask(); step(8);
    chk("R7 timer next", {16'd0, vec_hi}, 32'h1FF8);
    timer_req = 0; unmask(); step(8);
    chk("R7 spi next", {16'd0, vec_lo}, 32'h1FF5);
    spi_req = 0; unmask(); step(8);
    chk("R9 port b", {16'd0, vec_hi}, 32'h1FF2);
    pb_req = 0; t0 = ntake; unmask(); step(12);
    chk("R9 not latched", ntake - t0, 0);

    // mask write colliding with takes
    timer_req = 1; t0 = ntake;
    @(negedge clk); mask_wr = 1; mask_val = 0;
    step(12);
    mask_wr = 0; mask_val = 1; timer_req = 0; step(6);
    chk("R6 take beats write", {31'd0, (ntake - t0) >= 2}, 32'd1);
    step(4);
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected end", cycles);
    finish_run();
  end
endmodule